// File: doc/BRIEF.md
# Multi-Vector Group Row Address Sequencer

This block sits between instruction decode and the accumulator-array datapath of a vector unit. It takes the fields of a decoded multi-vector accumulate operation and produces the sequence of accesses that the operation needs. On each access it gives one accumulator-array row and one source vector register. A group has two or four vectors, and the block issues one access per vector on consecutive clocks.

The accumulator array has one row for every byte of the current vector length. The array is split into equal slices, one slice per vector in the group. The width of a slice is the stride. The first row comes from a 32-bit select value plus a small offset, wrapped into the first slice. Each later row lies exactly one stride further on, so each access falls in its own half or quarter of the array.

The source registers form an aligned, consecutive block. The block also tells the register file which general register supplies the select value.

Top module: `mvgrp_row_seq`

## Requirements
- R1: With `quad`=0 a sequence has 2 accesses; with `quad`=1 it has 4. Accesses are issued on consecutive clocks with `acc_valid` high, and `acc_step` counts 0, 1, ... up to the group size minus one.
- R2: The stride is (`vl_bits`/8) divided by the group size. `vl_bits` is a power of two from 128 to 2048.
- R3: The row of step 0 is (`sel_value` + `sel_offset`) mod 2^32, then reduced modulo the stride. The stride is a power of two, so this reduction keeps the low bits of the sum.
- R4: The row of each later step is the previous row plus the stride.
- R5: In pair mode, step r uses source register `zm_field`*2 + r. In quad mode, step r uses `zm_field[2:0]`*4 + r, and `zm_field[3]` has no effect.
- R6: `acc_done` is high exactly together with the last access. In the following cycle `acc_valid` is low.
- R7: When `start` is sampled high while idle, `acc_valid` goes high with step 0 on the next clock edge.
- R8: A `start` sampled while `acc_valid` is high has no effect, and that includes the cycle with `acc_done`. The fields captured at the start stay fixed until the sequence ends, even if the inputs change.
- R9: `base_gpr` gives the general register number 8 + `sel_field` (8 to 11) without a clock delay.
- R10: While reset is active, and after it is released, `acc_valid` and `acc_done` are low and `acc_step` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Requests a new sequence; accepted only while idle |
| sel_field | input | 2 | Chooses the select general register |
| sel_value | input | 32 | Value read from the select register |
| sel_offset | input | 3 | Row offset, 0 to 7 |
| zm_field | input | 4 | Source register group field |
| quad | input | 1 | 0: group of two, 1: group of four |
| vl_bits | input | 12 | Current vector length in bits |
| base_gpr | output | 4 | Number of the select general register (8 to 11) |
| acc_valid | output | 1 | An access is presented this cycle |
| row_idx | output | 8 | Accumulator-array row of this access |
| src_reg | output | 5 | Source vector register of this access |
| acc_step | output | 2 | Position of this access in the group |
| acc_done | output | 1 | This access is the last of the group |

## Verification
The bench runs every legal vector length in both group sizes, with all eight offsets and four select values. The select values are zero, a small value, the all-ones value and a large arbitrary value. Zero and the small value show that the offset is added before the wrap. The all-ones value shows that the carry out of 32 bits is dropped. The large value shows that only the bits below the stride survive.

The register field is varied together with the offset, so both field widths are covered and the unused top bit in quad mode is exercised. In some sequences, `start` is held high with changed inputs during the whole sequence, including the final access. These runs separate a design that latches the fields once from one that reads them live or restarts.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

  typedef enum logic {
    GRP_PAIR = 1'b0,
    GRP_QUAD = 1'b1
  } grp_e;

  localparam int unsigned DEF_MAX_VL  = 2048;
  localparam int unsigned DEF_SEL_W   = 32;
  localparam int unsigned DEF_OFF_W   = 3;
  localparam int unsigned DEF_ZREG_W  = 5;

endpackage

// File: rtl/mvs_stride_calc.sv
module mvs_stride_calc #(
  parameter int unsigned VL_W  = 12,
  parameter int unsigned ROW_W = 8
) (
  input  logic [VL_W-1:0]  vl_bits,
  input  mvs_pkg::grp_e    grp,
  output logic [ROW_W-1:0] stride,
  output logic [ROW_W-1:0] wrap_mask
);
  import mvs_pkg::*;

  // rows = bytes in one vector; slice width = rows / vectors in group
  function automatic logic [ROW_W-1:0] slice_width(input logic [VL_W-1:0] vl,
                                                   input grp_e g);
    logic [VL_W-1:0] rows;
    logic [VL_W-1:0] w;
    rows = vl >> 3;
    w    = (g == GRP_QUAD) ? (rows >> 2) : (rows >> 1);
    return w[ROW_W-1:0];
  endfunction

  always_comb begin
    stride    = slice_width(vl_bits, grp);
    wrap_mask = stride - ROW_W'(1);
  end

endmodule

// File: rtl/mvs_field_capture.sv
module mvs_field_capture #(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned ZREG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROW_W-1:0]  stride_d,
  input  logic [ZREG_W-1:0] src_base_d,
  input  mvs_pkg::grp_e     grp_d,
  output logic [ROW_W-1:0]  stride_q,
  output logic [ZREG_W-1:0] src_base_q,
  output mvs_pkg::grp_e     grp_q
);
  import mvs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q   <= '0;
      src_base_q <= '0;
      grp_q      <= GRP_PAIR;
    end else if (load) begin
      stride_q   <= stride_d;
      src_base_q <= src_base_d;
      grp_q      <= grp_d;
    end
  end

endmodule

// File: rtl/mvs_step_ctrl.sv
module mvs_step_ctrl #(
  parameter int unsigned STEP_W = 2,
  parameter int unsigned ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mvs_pkg::grp_e     grp_q,
  input  logic [ROW_W-1:0]  first_row_d,
  input  logic [ROW_W-1:0]  stride_q,
  output logic              load,
  output logic              valid_q,
  output logic              last,
  output logic [STEP_W-1:0] step_q,
  output logic [ROW_W-1:0]  row_q
);
  import mvs_pkg::*;

  localparam logic [STEP_W-1:0] LAST_PAIR = STEP_W'(1);
  localparam logic [STEP_W-1:0] LAST_QUAD = STEP_W'(3);

  function automatic logic [STEP_W-1:0] final_step(input grp_e g);
    return (g == GRP_QUAD) ? LAST_QUAD : LAST_PAIR;
  endfunction

  logic advance;

  always_comb begin
    load    = start && !valid_q;
    last    = valid_q && (step_q == final_step(grp_q));
    advance = valid_q && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      step_q  <= '0;
      row_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      step_q  <= '0;
      row_q   <= first_row_d;
    end else if (advance) begin
      step_q  <= step_q + STEP_W'(1);
      row_q   <= row_q + stride_q;
    end else if (last) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mvgrp_row_seq.sv
module mvgrp_row_seq #(
  parameter int unsigned MAX_VL = mvs_pkg::DEF_MAX_VL,
  parameter int unsigned SEL_W  = mvs_pkg::DEF_SEL_W,
  parameter int unsigned OFF_W  = mvs_pkg::DEF_OFF_W,
  parameter int unsigned ZREG_W = mvs_pkg::DEF_ZREG_W,
  localparam int unsigned VL_W   = $clog2(MAX_VL) + 1,
  localparam int unsigned ROW_W  = $clog2(MAX_VL / 8),
  localparam int unsigned ZF_W   = ZREG_W - 1,
  localparam int unsigned STEP_W = 2,
  localparam int unsigned GPR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        sel_field,
  input  logic [SEL_W-1:0]  sel_value,
  input  logic [OFF_W-1:0]  sel_offset,
  input  logic [ZF_W-1:0]   zm_field,
  input  logic              quad,
  input  logic [VL_W-1:0]   vl_bits,
  output logic [GPR_W-1:0]  base_gpr,
  output logic              acc_valid,
  output logic [ROW_W-1:0]  row_idx,
  output logic [ZREG_W-1:0] src_reg,
  output logic [STEP_W-1:0] acc_step,
  output logic              acc_done
);
  import mvs_pkg::*;

  // Aligned source block: pair -> field*2, quad -> low field bits * 4
  function automatic logic [ZREG_W-1:0] src_block(input logic [ZF_W-1:0] f,
                                                  input grp_e g);
    return (g == GRP_QUAD) ? {f[ZF_W-2:0], 2'b00} : {f, 1'b0};
  endfunction

  // Full-width add, carry out dropped, then wrap into first slice
  function automatic logic [ROW_W-1:0] wrap_start(input logic [SEL_W-1:0] base,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [ROW_W-1:0] msk);
    logic [SEL_W-1:0] sum;
    sum = base + SEL_W'(off);
    return sum[ROW_W-1:0] & msk;
  endfunction

  grp_e              grp_d;
  grp_e              grp_q;
  logic [ROW_W-1:0]  stride_d;
  logic [ROW_W-1:0]  wrap_mask;
  logic [ROW_W-1:0]  first_row_d;
  logic [ZREG_W-1:0] src_base_d;
  logic [ROW_W-1:0]  stride_q;
  logic [ZREG_W-1:0] src_base_q;
  logic              quad_q;
  logic              load;
  logic              valid_q;
  logic              last;
  logic [STEP_W-1:0] step_q;
  logic [ROW_W-1:0]  row_q;

  assign grp_d       = quad ? GRP_QUAD : GRP_PAIR;
  assign quad_q      = (grp_q == GRP_QUAD);
  assign first_row_d = wrap_start(sel_value, sel_offset, wrap_mask);
  assign src_base_d  = src_block(zm_field, grp_d);

  mvs_stride_calc #(.VL_W(VL_W), .ROW_W(ROW_W)) u_stride (
    .vl_bits   (vl_bits),
    .grp       (grp_d),
    .stride    (stride_d),
    .wrap_mask (wrap_mask)
  );

  mvs_field_capture #(.ROW_W(ROW_W), .ZREG_W(ZREG_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .stride_d   (stride_d),
    .src_base_d (src_base_d),
    .grp_d      (grp_d),
    .stride_q   (stride_q),
    .src_base_q (src_base_q),
    .grp_q      (grp_q)
  );

  mvs_step_ctrl #(.STEP_W(STEP_W), .ROW_W(ROW_W)) u_step (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .grp_q       (grp_q),
    .first_row_d (first_row_d),
    .stride_q    (stride_q),
    .load        (load),
    .valid_q     (valid_q),
    .last        (last),
    .step_q      (step_q),
    .row_q       (row_q)
  );

  assign base_gpr  = {2'b10, sel_field};
  assign acc_valid = valid_q;
  assign acc_done  = last;
  assign acc_step  = step_q;
  assign row_idx   = row_q;
  assign src_reg   = src_base_q + ZREG_W'(step_q);

endmodule

// File: rtl/mvgrp_row_seq_chk.sv
module mvgrp_row_seq_chk #(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned ZREG_W = 5,
  parameter int unsigned STEP_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_done,
  input logic [STEP_W-1:0] acc_step,
  input logic [ROW_W-1:0]  row_idx,
  input logic [ZREG_W-1:0] src_reg,
  input logic [ROW_W-1:0]  stride_q,
  input logic [ZREG_W-1:0] src_base_q,
  input logic              quad_q
);

  AST_DONE_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> acc_valid); // R6

  AST_DONE_ENDS_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_valid); // R6

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_done) |=> (acc_valid && acc_step == $past(acc_step) + STEP_W'(1))); // R1

  AST_ROW_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_done) |=> (row_idx == $past(row_idx) + $past(stride_q))); // R4

  AST_SRC_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_done) |=> (src_reg == $past(src_reg) + ZREG_W'(1))); // R5

  AST_FIRST_ROW_IN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_step == '0) |-> (row_idx < stride_q)); // R3

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ($stable(stride_q) && $stable(src_base_q) && $stable(quad_q))); // R8

  AST_GROUP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> (acc_step == (quad_q ? STEP_W'(3) : STEP_W'(1)))); // R1

endmodule

bind mvgrp_row_seq mvgrp_row_seq_chk #(.ROW_W(ROW_W), .ZREG_W(ZREG_W), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/mvgrp_row_seq_test.sv
`timescale 1ns/1ps
module mvgrp_row_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sel_field = '0;
  logic [31:0] sel_value = '0;
  logic [2:0]  sel_offset = '0;
  logic [3:0]  zm_field = '0;
  logic        quad = 1'b0;
  logic [11:0] vl_bits = 12'd128;
  logic [3:0]  base_gpr;
  logic        acc_valid;
  logic [7:0]  row_idx;
  logic [4:0]  src_reg;
  logic [1:0]  acc_step;
  logic        acc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mvgrp_row_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_field(sel_field),
    .sel_value(sel_value), .sel_offset(sel_offset), .zm_field(zm_field),
    .quad(quad), .vl_bits(vl_bits), .base_gpr(base_gpr),
    .acc_valid(acc_valid), .row_idx(row_idx), .src_reg(src_reg),
    .acc_step(acc_step), .acc_done(acc_done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sequence; poke holds start high with altered inputs while busy (R8)
  task automatic run_seq(input int vl, input bit q, input logic [31:0] sv,
                         input int off, input int zm, input int sf, input bit poke);
    int g;
    int stride;
    longint sum;
    int first;
    int sbase;
    @(negedge clk);
    vl_bits = 12'(vl); quad = q; sel_value = sv; sel_offset = 3'(off);
    zm_field = 4'(zm); sel_field = 2'(sf); start = 1'b1;
    #1 check("R9 base_gpr", base_gpr, 8 + sf);
    g      = q ? 4 : 2;
    stride = (vl / 8) / g;                       // R2
    sum    = (longint'(sv) + off) % (64'd1 << 32); // R3 carry dropped
    first  = int'(sum % stride);
    sbase  = q ? (zm % 8) * 4 : zm * 2;          // R5
    for (int r = 0; r < g; r++) begin
      @(negedge clk);
      if (poke) begin
        start = 1'b1; sel_value = ~sv; sel_offset = 3'(off + 1);
        zm_field = 4'(zm + 1); quad = ~q; vl_bits = (vl == 2048) ? 12'd128 : 12'(vl * 2);
      end else begin
        start = 1'b0;
      end
      check(r == 0 ? "R7 valid after start" : "R1 valid", acc_valid, 1);
      check("R1 step", acc_step, r);
      check(r == 0 ? "R3 first row" : "R4 row stride", row_idx, first + r * stride);
      check("R5 src reg", src_reg, sbase + r);
      check("R6 done with last", acc_done, (r == g - 1) ? 1 : 0);
    end
    @(negedge clk);
    start = 1'b0;
    check(poke ? "R8 start ignored at done" : "R6 valid drops", acc_valid, 0);
    check("R6 done low", acc_done, 0);
  endtask

  initial begin
    #1;
    check("R10 valid in reset", acc_valid, 0);
    check("R10 done in reset", acc_done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", acc_valid, 0);
    check("R10 step after reset", acc_step, 0);
    for (int k = 0; k < 5; k++) begin
      for (int q = 0; q < 2; q++) begin
        for (int off = 0; off < 8; off++) begin
          for (int s = 0; s < 4; s++) begin
            logic [31:0] sv;
            case (s)
              0: sv = 32'h0;
              1: sv = 32'h5;
              2: sv = 32'hFFFF_FFFF;
              default: sv = 32'h1234_5677;
            endcase
            run_seq(128 << k, q[0], sv, off, (off * 3 + s + k) % 16,
                    (off + s) % 4, (off == 3) || (s == 2 && off == 6));
          end
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule